// File: doc/BRIEF.md
# Two-Bit Usage Victim Selector

This block keeps replacement state for a small group of cache blocks and names the block to evict when asked. For every block it holds two usage flags: a short-term flag and a long-term flag. Any access to a block raises both of its flags. Both kinds of flag are also wiped across all blocks on their own schedules, which count accesses. The short-term flags are wiped every `VRU_PERIOD` accesses. The long-term flags are wiped at every `RU_RATIO`-th short-term wipe. The result is that a block's two flags show how long ago it was last touched.

When a victim is requested, the caller supplies a mask of the blocks that may be evicted. The selector first looks for a candidate with both flags low. Failing that, it looks for a candidate with only the long-term flag high. If neither class has a member, it falls back to a pseudo-random candidate. The random start point comes from a free-running 8-bit LFSR. The victim output is combinational from the stored flags, the mask and the LFSR. This lets a miss handler read it in the same cycle as it raises its request. Tags and data live elsewhere.

Top module: `nru2_victim_sel`

## Requirements
- R1: After reset all flags are low, so a request with mask 8'hFF returns block 0 with `vic_vld_o` high.
- R2: An access (`acc_vld_i` high at a clock edge, block number in binary on `acc_idx_i`) sets both flags of that block, visible from the next cycle.
- R3: If any candidate (mask bit i selects block i) has both flags low, the victim is the lowest-numbered such candidate.
- R4: On every `VRU_PERIOD`-th access since reset (default 4), all short-term flags are cleared, except for the block accessed in that same cycle.
- R5: On every `VRU_PERIOD*RU_RATIO`-th access (default 16), all long-term flags are cleared as well, except for the block accessed in that same cycle.
- R6: If no candidate has both flags low, but some candidate has only the long-term flag high, the victim is the lowest-numbered such candidate.
- R7: Otherwise the victim is a pseudo-random candidate. The search starts at block number `lfsr mod NUM_BLK` and wraps upward. The LFSR advances every cycle, so repeated requests with the same state reach different candidates.
- R8: A block accessed in the same cycle as a periodic clear keeps both flags set.
- R9: `vic_vld_o` is high only when `vic_req_i` is high and the mask is non-zero. A valid victim is always a block whose mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously inside |
| acc_vld_i | input | 1 | Access strobe |
| acc_idx_i | input | $clog2(NUM_BLK) | Accessed block number |
| cand_mask_i | input | NUM_BLK | Blocks eligible for eviction |
| vic_req_i | input | 1 | Victim request |
| vic_vld_o | output | 1 | Victim index valid |
| vic_idx_o | output | $clog2(NUM_BLK) | Chosen victim block |

## Verification
The assertions check four things on every cycle. A valid victim is always inside the mask. There is no victim without a request. An access raises both flags one cycle later. The short-term flag never stands alone without the long-term flag. The class priority is also checked on every cycle: a candidate with both flags low, or else one with only the long-term flag high, is always preferred.

The bench scenarios show the behaviour that depends on history. They reach the clears on the exact access counts, and show that an access coinciding with a clear survives it. They check lowest-index order within a class, and show that the random fallback spreads over several candidates as the LFSR runs.

// File: rtl/nru2_pkg.sv
package nru2_pkg;
  localparam int unsigned LFSR_W = 8;

  // x^8 + x^6 + x^5 + x^4 + 1, shift toward MSB
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/nru2_lfsr.sv
module nru2_lfsr
  import nru2_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] st_d, st_q;

  always_comb st_d = lfsr_step(st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LFSR_W'(1);
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/nru2_usage_track.sv
module nru2_usage_track #(
  parameter int unsigned NUM_BLK    = 8,
  parameter int unsigned VRU_PERIOD = 4,
  parameter int unsigned RU_RATIO   = 4,
  localparam int unsigned IDX_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int unsigned CNT_W = (VRU_PERIOD > 1) ? $clog2(VRU_PERIOD) : 1,
  localparam int unsigned GRP_W = (RU_RATIO > 1) ? $clog2(RU_RATIO) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_vld_i,
  input  logic [IDX_W-1:0]   acc_idx_i,
  output logic [NUM_BLK-1:0] ru_o,
  output logic [NUM_BLK-1:0] vru_o
);
  logic [CNT_W-1:0]   cnt_d, cnt_q;
  logic [GRP_W-1:0]   grp_d, grp_q;
  logic [NUM_BLK-1:0] ru_d, ru_q, vru_d, vru_q, hit;
  logic               clr_short, clr_long;

  always_comb begin
    cnt_d     = cnt_q;
    grp_d     = grp_q;
    clr_short = 1'b0;
    clr_long  = 1'b0;
    hit       = '0;
    if (acc_vld_i) begin
      hit[acc_idx_i] = 1'b1;
      if (cnt_q == CNT_W'(VRU_PERIOD - 1)) begin
        cnt_d     = '0;
        clr_short = 1'b1;
        if (grp_q == GRP_W'(RU_RATIO - 1)) begin
          grp_d    = '0;
          clr_long = 1'b1;
        end else begin
          grp_d = grp_q + GRP_W'(1);
        end
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    // the accessed block wins over a same-cycle wipe
    vru_d = (clr_short ? '0 : vru_q) | hit;
    ru_d  = (clr_long  ? '0 : ru_q)  | hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      grp_q <= '0;
      ru_q  <= '0;
      vru_q <= '0;
    end else if (acc_vld_i) begin
      cnt_q <= cnt_d;
      grp_q <= grp_d;
      ru_q  <= ru_d;
      vru_q <= vru_d;
    end
  end

  assign ru_o  = ru_q;
  assign vru_o = vru_q;
endmodule

// File: rtl/nru2_pick.sv
module nru2_pick #(
  parameter int unsigned NUM_BLK = 8,
  localparam int unsigned IDX_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic [NUM_BLK-1:0] cand_i,
  input  logic [NUM_BLK-1:0] ru_i,
  input  logic [NUM_BLK-1:0] vru_i,
  input  logic [IDX_W-1:0]   rnd_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_BLK-1:0] cls_idle, cls_old;
  logic [IDX_W-1:0]   idx_idle, idx_old, idx_rnd, j;
  logic               f_idle, f_old, f_rnd;

  assign cls_idle = cand_i & ~ru_i & ~vru_i;
  assign cls_old  = cand_i &  ru_i & ~vru_i;

  always_comb begin
    f_idle = 1'b0; idx_idle = '0;
    f_old  = 1'b0; idx_old  = '0;
    f_rnd  = 1'b0; idx_rnd  = '0;
    j      = '0;
    for (int k = 0; k < NUM_BLK; k++) begin
      if (!f_idle && cls_idle[k]) begin
        f_idle = 1'b1; idx_idle = IDX_W'(k);
      end
      if (!f_old && cls_old[k]) begin
        f_old = 1'b1; idx_old = IDX_W'(k);
      end
    end
    for (int k = 0; k < NUM_BLK; k++) begin
      j = IDX_W'((32'(rnd_i) + 32'(k)) % NUM_BLK);
      if (!f_rnd && cand_i[j]) begin
        f_rnd = 1'b1; idx_rnd = j;
      end
    end
  end

  assign any_o = f_rnd;
  assign idx_o = f_idle ? idx_idle : (f_old ? idx_old : idx_rnd);
endmodule

// File: rtl/nru2_victim_sel.sv
module nru2_victim_sel #(
  parameter int unsigned NUM_BLK    = 8,
  parameter int unsigned VRU_PERIOD = 4,
  parameter int unsigned RU_RATIO   = 4,
  localparam int unsigned IDX_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_vld_i,
  input  logic [IDX_W-1:0]   acc_idx_i,
  input  logic [NUM_BLK-1:0] cand_mask_i,
  input  logic               vic_req_i,
  output logic               vic_vld_o,
  output logic [IDX_W-1:0]   vic_idx_o
);
  import nru2_pkg::*;

  logic [1:0]         rst_sync_q;
  logic               rst_n_sync;
  logic [LFSR_W-1:0]  lfsr;
  logic [NUM_BLK-1:0] ru_bits, vru_bits;
  logic               any_cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  nru2_lfsr i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .state_o (lfsr)
  );

  nru2_usage_track #(
    .NUM_BLK    (NUM_BLK),
    .VRU_PERIOD (VRU_PERIOD),
    .RU_RATIO   (RU_RATIO)
  ) i_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .acc_vld_i (acc_vld_i),
    .acc_idx_i (acc_idx_i),
    .ru_o      (ru_bits),
    .vru_o     (vru_bits)
  );

  nru2_pick #(.NUM_BLK(NUM_BLK)) i_pick (
    .cand_i (cand_mask_i),
    .ru_i   (ru_bits),
    .vru_i  (vru_bits),
    .rnd_i  (lfsr[IDX_W-1:0]),
    .any_o  (any_cand),
    .idx_o  (vic_idx_o)
  );

  assign vic_vld_o = vic_req_i & any_cand;
endmodule

// File: rtl/nru2_victim_sel_chk.sv
module nru2_victim_sel_chk #(
  parameter int unsigned NUM_BLK = 8,
  localparam int unsigned IDX_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic               acc_vld_i,
  input logic [IDX_W-1:0]   acc_idx_i,
  input logic [NUM_BLK-1:0] cand_mask_i,
  input logic               vic_req_i,
  input logic               vic_vld_o,
  input logic [IDX_W-1:0]   vic_idx_o,
  input logic [NUM_BLK-1:0] ru_bits,
  input logic [NUM_BLK-1:0] vru_bits
);
  // R9
  victim_in_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    vic_vld_o |-> cand_mask_i[vic_idx_o]);

  // R9
  no_req_no_victim_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !vic_req_i |-> !vic_vld_o);

  // R2
  access_sets_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    acc_vld_i |=> (ru_bits[$past(acc_idx_i)] && vru_bits[$past(acc_idx_i)]));

  // R4
  short_implies_long_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (vru_bits & ~ru_bits) == '0);

  // R3
  idle_class_first_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (vic_vld_o && |(cand_mask_i & ~ru_bits & ~vru_bits))
      |-> (!ru_bits[vic_idx_o] && !vru_bits[vic_idx_o]));

  // R6
  old_class_second_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (vic_vld_o && !(|(cand_mask_i & ~ru_bits & ~vru_bits))
               && |(cand_mask_i & ru_bits & ~vru_bits))
      |-> (ru_bits[vic_idx_o] && !vru_bits[vic_idx_o]));
endmodule

bind nru2_victim_sel nru2_victim_sel_chk #(.NUM_BLK(NUM_BLK)) i_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n_sync),
  .acc_vld_i   (acc_vld_i),
  .acc_idx_i   (acc_idx_i),
  .cand_mask_i (cand_mask_i),
  .vic_req_i   (vic_req_i),
  .vic_vld_o   (vic_vld_o),
  .vic_idx_o   (vic_idx_o),
  .ru_bits     (ru_bits),
  .vru_bits    (vru_bits)
);

// File: tb/test_nru2_victim_sel.sv
module test_nru2_victim_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_vld;
  logic [IW-1:0] acc_idx;
  logic [NB-1:0] mask;
  logic          req;
  logic          vld;
  logic [IW-1:0] idx;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nru2_victim_sel i_nru2_victim_sel (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .acc_vld_i   (acc_vld),
    .acc_idx_i   (acc_idx),
    .cand_mask_i (mask),
    .vic_req_i   (req),
    .vic_vld_o   (vld),
    .vic_idx_o   (idx)
  );

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acc_vld = 1'b0; acc_idx = '0; mask = '0; req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic touch(input int b);
    @(negedge clk);
    acc_vld = 1'b1; acc_idx = IW'(b);
    @(negedge clk);
    acc_vld = 1'b0;
  endtask

  task automatic expect_vic(input string tag, input logic [NB-1:0] m,
                            input logic ev, input int ei);
    @(negedge clk);
    mask = m; req = 1'b1;
    #1;
    n_vec++;
    if (vld !== ev || (ev && idx !== IW'(ei))) begin
      n_fail++;
      $display("FAIL %s mask=%b: vld=%b idx=%0d expected vld=%b idx=%0d",
               tag, m, vld, idx, ev, ei);
    end
    req = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    expect_vic("R1", 8'hFF, 1'b1, 0);
    expect_vic("R9 empty mask", 8'h00, 1'b0, 0);
    @(negedge clk);
    mask = 8'hFF; req = 1'b0; #1;
    n_vec++;
    if (vld !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 no request: vld=%b expected 0", vld);
    end
  endtask

  task automatic t_access_and_idle();
    do_reset();
    touch(0); touch(2);
    expect_vic("R2", 8'b0000_0101, 1'b1, 0);   // both touched: random, but 0 first pass below
    expect_vic("R2 untouched wins", 8'b0000_0111, 1'b1, 1);
    expect_vic("R3 lowest idle", 8'b0000_1111, 1'b1, 1);
    expect_vic("R3 skip touched", 8'b0000_1101, 1'b1, 3);
  endtask

  task automatic t_short_clear();
    do_reset();
    touch(4); touch(0); touch(1); touch(3);      // 4th access wipes short flags
    expect_vic("R4 R6 old beats fresh", 8'b0000_1001, 1'b1, 0);
    expect_vic("R6 lowest old", 8'b0001_1010, 1'b1, 1);
    expect_vic("R8 same-cycle access kept", 8'b0001_1000, 1'b1, 4);
  endtask

  task automatic t_long_clear();
    do_reset();
    touch(6);
    for (int i = 0; i < 15; i++) touch(1);      // 16th access wipes long flags
    touch(0); touch(2); touch(2); touch(2);      // 20th access wipes short flags
    // 0 old-only, 2 fresh, 6 idle only if long flags were wiped
    expect_vic("R5 long wipe", 8'b0100_0001, 1'b1, 6);
    expect_vic("R8 survives", 8'b0000_0101, 1'b1, 0);
  endtask

  task automatic t_random();
    logic [NB-1:0] seen;
    int cnt;
    do_reset();
    touch(0); touch(1); touch(2);
    seen = '0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      mask = 8'b0000_0111; req = 1'b1; #1;
      n_vec++;
      if (vld !== 1'b1 || idx > 3'd2) begin
        n_fail++;
        $display("FAIL R7 random pick: vld=%b idx=%0d expected vld=1 idx in 0..2", vld, idx);
      end else begin
        seen[idx] = 1'b1;
      end
    end
    req = 1'b0;
    cnt = $countones(seen);
    n_vec++;
    if (cnt < 2) begin
      n_fail++;
      $display("FAIL R7 spread: distinct=%0d expected >=2", cnt);
    end
  endtask

  initial begin
    rst_n = 1'b0; acc_vld = 1'b0; acc_idx = '0; mask = '0; req = 1'b0;
    t_reset_state();
    t_access_and_idle();
    t_short_clear();
    t_long_clear();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule